// File: doc/BRIEF.md
# Sensor Sample Byte FIFO Packer

This block gathers one sample set on every sample tick and stores it in a byte-wide FIFO for a host to drain. The set can hold three accelerometer words, one temperature word, three gyro words and a parameterised number of auxiliary bytes. A four-bit enable mask picks which sources take part, so a set is anywhere from 2 to 14 + AUX_BYTES bytes long. The state of an external sync input can be folded into the least-significant bit of one chosen word, so it costs no extra bytes.

Each set is copied into storage one byte per cycle. The fill count grows only when the last byte of the set has been stored, so a host never sees a partial set. When a set does not fit, the oldest bytes are dropped to make room and an overflow flag is raised. The host reaches the FIFO through a small read port with three selectors. One pops data bytes in a burst. One returns the high byte of the 16-bit fill count and latches its low byte at the same moment. The third returns that latched low byte. A data-ready flag reports each set as it is stored, and a one-cycle FIFO reset input empties the FIFO.

Top module: `sample_fifo_packer`

## Requirements
- R1: A set is written in this order: accel X, Y, Z (when cfg_en[0]=1), temperature (cfg_en[1]), gyro X, Y, Z (cfg_en[2]), then the auxiliary bytes (cfg_en[3]). Each 16-bit word goes high byte first. Auxiliary byte 0 is aux_data[8*AUX_BYTES-1 -: 8]. A tick with cfg_en=0 writes nothing.
- R2: When sync_sel=k (k in 1..7), bit 0 of word k-1 in the order accel X, accel Y, accel Z, temp, gyro X, gyro Y, gyro Z is replaced by sync_in as sampled at the tick. When sync_sel=0, every word is stored unchanged.
- R3: A read with rd_sel=1 returns bits 15:8 of the fill count and latches bits 7:0. A later read with rd_sel=2 returns the latched byte, even if the count has changed in between.
- R4: A read with rd_sel=0 pops the oldest byte. Back-to-back pops return bytes in the order they were written. rd_data holds the read result from the clock edge that follows rd_en.
- R5: A pop on an empty FIFO returns the last byte that was popped, and the count stays at zero.
- R6: The fill count grows by a whole set only when its last byte is stored, which happens size cycles after the tick. A tick that arrives while a set is still being written is ignored.
- R7: When the free space is smaller than the set, exactly the shortfall of oldest bytes is discarded, irq_overflow is set, and the count never goes above DEPTH.
- R8: irq_data_rdy is set when a set is stored. irq_ack clears both flags. A flag stays set until it is acknowledged.
- R9: A fifo_rst pulse empties the FIFO, so the count reads 0 on the next cycle.
- R10: After rst_n, the count is 0, both flags are 0 and rd_data is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sample_tick | input | 1 | Capture one sample set |
| cfg_en | input | 4 | Source enables: accel, temp, gyro, aux |
| sync_sel | input | 3 | Word that carries sync_in in its LSB (0 = none) |
| sync_in | input | 1 | External sync level |
| accel_x | input | 16 | Accelerometer X |
| accel_y | input | 16 | Accelerometer Y |
| accel_z | input | 16 | Accelerometer Z |
| temp | input | 16 | Temperature |
| gyro_x | input | 16 | Gyro X |
| gyro_y | input | 16 | Gyro Y |
| gyro_z | input | 16 | Gyro Z |
| aux_data | input | 8*AUX_BYTES | Auxiliary sensor bytes |
| fifo_rst | input | 1 | One-cycle FIFO clear |
| rd_en | input | 1 | Register read strobe |
| rd_sel | input | 2 | 0 data pop, 1 count high, 2 count low latch |
| rd_data | output | 8 | Read result |
| irq_ack | input | 1 | Clear both flags |
| irq_data_rdy | output | 1 | A set has been stored |
| irq_overflow | output | 1 | Bytes were discarded |

## Verification
Some properties are checked on every cycle. The fill level never exceeds the capacity, and a FIFO reset leaves it at zero. The overflow flag rises only right after a tick. The data-ready flag rises only together with a growth of the fill level. Other behaviour can only be shown by the bench's scenarios. These cover the packed byte order for each enable mask and sync choice, the popped sequence, the latched count halves, and a count that stays unchanged while a set is still being written. They also cover the exact bytes left after an overflow discard and the repeat of the last byte on an empty pop.

// File: rtl/sample_fifo_packer.sv
module sample_fifo_packer #(
  parameter int DEPTH     = 1024,
  parameter int AUX_BYTES = 2
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   sample_tick,
  input  logic [3:0]             cfg_en,
  input  logic [2:0]             sync_sel,
  input  logic                   sync_in,
  input  logic [15:0]            accel_x,
  input  logic [15:0]            accel_y,
  input  logic [15:0]            accel_z,
  input  logic [15:0]            temp,
  input  logic [15:0]            gyro_x,
  input  logic [15:0]            gyro_y,
  input  logic [15:0]            gyro_z,
  input  logic [8*AUX_BYTES-1:0] aux_data,
  input  logic                   fifo_rst,
  input  logic                   rd_en,
  input  logic [1:0]             rd_sel,
  output logic [7:0]             rd_data,
  input  logic                   irq_ack,
  output logic                   irq_data_rdy,
  output logic                   irq_overflow
);
  localparam int AW   = $clog2(DEPTH);
  localparam int CW   = AW + 1;
  localparam int MAXB = 14 + AUX_BYTES;
  localparam int SW   = $clog2(MAXB + 1);

  logic [7:0]    mem [DEPTH];
  logic [AW-1:0] wr_ptr, rd_ptr;
  logic [CW-1:0] cnt;
  logic          busy;
  logic [SW-1:0] wcnt, size_q;
  logic [7:0]    pk_q [MAXB];
  logic [7:0]    last_byte, cnt_lat;

  logic [15:0]   w [7];
  logic [7:0]    pk [MAXB];
  logic [SW-1:0] psize;

  always_comb begin
    w[0] = accel_x; w[1] = accel_y; w[2] = accel_z; w[3] = temp;
    w[4] = gyro_x;  w[5] = gyro_y;  w[6] = gyro_z;
    for (int i = 0; i < 7; i++)
      if (sync_sel == 3'(i + 1)) w[i][0] = sync_in;
  end

  always_comb begin
    logic [SW-1:0] n;
    logic          en;
    n = '0;
    for (int i = 0; i < MAXB; i++) pk[i] = '0;
    for (int i = 0; i < 7; i++) begin
      en = (i < 3) ? cfg_en[0] : (i == 3) ? cfg_en[1] : cfg_en[2];
      if (en) begin
        pk[n]      = w[i][15:8];
        pk[n + 1'b1] = w[i][7:0];
        n = n + SW'(2);
      end
    end
    if (cfg_en[3])
      for (int j = 0; j < AUX_BYTES; j++) begin
        pk[n] = aux_data[8*(AUX_BYTES-1-j) +: 8];
        n = n + 1'b1;
      end
    psize = n;
  end

  wire           start  = sample_tick && !busy && psize != '0 && !fifo_rst;
  wire           pop    = rd_en && rd_sel == 2'd0 && cnt != '0 && !fifo_rst;
  wire           commit = busy && wcnt == size_q - 1'b1;
  wire [CW-1:0]  need   = CW'(psize);
  wire [CW-1:0]  free_b = CW'(DEPTH) - (cnt - CW'(pop));
  wire [CW-1:0]  drop   = (start && need > free_b) ? need - free_b : '0;
  wire [15:0]    cnt16  = 16'(cnt);

  always_ff @(posedge clk) begin
    if (busy && !fifo_rst) mem[wr_ptr + AW'(wcnt)] <= pk_q[wcnt];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0; rd_ptr <= '0; cnt <= '0;
      busy <= 1'b0; wcnt <= '0; size_q <= '0;
      for (int i = 0; i < MAXB; i++) pk_q[i] <= '0;
    end else if (fifo_rst) begin
      wr_ptr <= '0; rd_ptr <= '0; cnt <= '0;
      busy <= 1'b0; wcnt <= '0;
    end else begin
      rd_ptr <= rd_ptr + AW'(pop) + AW'(drop);
      cnt    <= cnt - CW'(pop) - drop + (commit ? CW'(size_q) : '0);
      if (start) begin
        busy <= 1'b1; wcnt <= '0; size_q <= psize;
        for (int i = 0; i < MAXB; i++) pk_q[i] <= pk[i];
      end else if (busy) begin
        wcnt <= wcnt + 1'b1;
        if (commit) begin
          busy   <= 1'b0;
          wr_ptr <= wr_ptr + AW'(size_q);
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_data <= '0; last_byte <= '0; cnt_lat <= '0;
      irq_data_rdy <= 1'b0; irq_overflow <= 1'b0;
    end else begin
      irq_data_rdy <= (irq_data_rdy & ~irq_ack) | (commit & ~fifo_rst);
      irq_overflow <= (irq_overflow & ~irq_ack) | (drop != '0);
      if (rd_en)
        case (rd_sel)
          2'd0: if (pop) begin
                  rd_data   <= mem[rd_ptr];
                  last_byte <= mem[rd_ptr];
                end else rd_data <= last_byte;
          2'd1: begin rd_data <= cnt16[15:8]; cnt_lat <= cnt16[7:0]; end
          2'd2: rd_data <= cnt_lat;
          default: rd_data <= '0;
        endcase
    end
  end
endmodule

// File: rtl/sample_fifo_packer_chk.sv
module sample_fifo_packer_chk #(
  parameter int DEPTH = 1024,
  parameter int CW    = 11
) (
  input logic          clk,
  input logic          rst_n,
  input logic          sample_tick,
  input logic          fifo_rst,
  input logic [CW-1:0] cnt,
  input logic          irq_overflow,
  input logic          irq_data_rdy
);
  a_r7_fill_bound: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= CW'(DEPTH));
  a_r9_rst_empties: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_rst |=> cnt == '0);
  a_r7_ovf_after_tick: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_overflow) |-> $past(sample_tick));
  a_r8_rdy_with_growth: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_data_rdy) |-> cnt > $past(cnt));
endmodule

bind sample_fifo_packer sample_fifo_packer_chk #(.DEPTH(DEPTH), .CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_n), .sample_tick(sample_tick), .fifo_rst(fifo_rst),
  .cnt(cnt), .irq_overflow(irq_overflow), .irq_data_rdy(irq_data_rdy));

// File: tb/sim_sample_fifo_packer.sv
module sim_sample_fifo_packer;
  localparam int CLK_P = 10;
  localparam int DEPTH = 1024;
  localparam int AUXB  = 2;

  logic clk = 0, rst_n = 0, sample_tick = 0, sync_in = 0, fifo_rst = 0;
  logic rd_en = 0, irq_ack = 0;
  logic [3:0] cfg_en = 0;
  logic [2:0] sync_sel = 0;
  logic [1:0] rd_sel = 0;
  logic [15:0] ax = 0, ay = 0, az = 0, tp = 0, gx = 0, gy = 0, gz = 0;
  logic [8*AUXB-1:0] aux = 0;
  logic [7:0] rd_data;
  logic irq_data_rdy, irq_overflow;

  int checks = 0, errors = 0;
  bit done = 0;
  logic [7:0] mq[$];
  logic [7:0] last_pop = 0;

  always #(CLK_P/2) clk = ~clk;

  sample_fifo_packer #(.DEPTH(DEPTH), .AUX_BYTES(AUXB)) u0 (
    .clk(clk), .rst_n(rst_n), .sample_tick(sample_tick), .cfg_en(cfg_en),
    .sync_sel(sync_sel), .sync_in(sync_in), .accel_x(ax), .accel_y(ay),
    .accel_z(az), .temp(tp), .gyro_x(gx), .gyro_y(gy), .gyro_z(gz),
    .aux_data(aux), .fifo_rst(fifo_rst), .rd_en(rd_en), .rd_sel(rd_sel),
    .rd_data(rd_data), .irq_ack(irq_ack), .irq_data_rdy(irq_data_rdy),
    .irq_overflow(irq_overflow));

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int set_bytes(output logic [7:0] b[$]);
    logic [15:0] w [7];
    bit en;
    b = {};
    w[0] = ax; w[1] = ay; w[2] = az; w[3] = tp; w[4] = gx; w[5] = gy; w[6] = gz;
    if (sync_sel != 0) w[sync_sel-1][0] = sync_in;
    for (int i = 0; i < 7; i++) begin
      en = (i < 3) ? cfg_en[0] : (i == 3) ? cfg_en[1] : cfg_en[2];
      if (en) begin b.push_back(w[i][15:8]); b.push_back(w[i][7:0]); end
    end
    if (cfg_en[3])
      for (int j = 0; j < AUXB; j++) b.push_back(aux[8*(AUXB-1-j) +: 8]);
    return b.size();
  endfunction

  task automatic rd(input logic [1:0] s, output logic [7:0] v);
    rd_en = 1; rd_sel = s;
    @(negedge clk);
    rd_en = 0;
    v = rd_data;
  endtask

  task automatic count_check(input string req);
    logic [7:0] h, l;
    rd(2'd1, h); rd(2'd2, l);
    check({h, l} == 16'(mq.size()), req, {h, l}, mq.size());
  endtask

  task automatic pop_check(input int k, input string req);
    logic [7:0] v, e;
    for (int i = 0; i < k; i++) begin
      rd(2'd0, v);
      e = mq.pop_front();
      last_pop = e;
      check(v == e, req, v, e);
    end
  endtask

  task automatic tick(output bit ovf);
    logic [7:0] b[$];
    int n;
    n = set_bytes(b);
    ovf = 0;
    sample_tick = 1;
    @(negedge clk);
    sample_tick = 0;
    while (mq.size() + n > DEPTH) begin void'(mq.pop_front()); ovf = 1; end
    foreach (b[i]) mq.push_back(b[i]);
    repeat (MAXW) @(negedge clk);
  endtask
  localparam int MAXW = 14 + AUXB + 3;

  task automatic rand_inputs();
    ax = 16'($urandom); ay = 16'($urandom); az = 16'($urandom); tp = 16'($urandom);
    gx = 16'($urandom); gy = 16'($urandom); gz = 16'($urandom);
    aux = (8*AUXB)'($urandom); sync_in = 1'($urandom); sync_sel = 3'($urandom);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual 0 expected 1");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    bit ovf;
    logic [7:0] v, h, l;
    void'($urandom(32'h5eed));
    repeat (3) @(negedge clk);
    // R10 reset state
    check(rd_data == 0, "R10", rd_data, 0);
    check(irq_data_rdy == 0 && irq_overflow == 0, "R10", {irq_data_rdy, irq_overflow}, 0);
    rst_n = 1;
    @(negedge clk);
    count_check("R10");

    // R1 directed: all sources, no sync
    cfg_en = 4'hF; sync_sel = 0;
    ax = 16'h0102; ay = 16'h0304; az = 16'h0506; tp = 16'h0708;
    gx = 16'h090A; gy = 16'h0B0C; gz = 16'h0D0E; aux = 16'h0F10;
    tick(ovf);
    count_check("R1");
    pop_check(16, "R1");
    // R8 data-ready set, then ack clears it
    check(irq_data_rdy == 1, "R8", irq_data_rdy, 1);
    irq_ack = 1; @(negedge clk); irq_ack = 0;
    check(irq_data_rdy == 0, "R8", irq_data_rdy, 0);

    // R1 empty mask writes nothing
    cfg_en = 0; tick(ovf);
    count_check("R1");
    check(irq_data_rdy == 0, "R1", irq_data_rdy, 0);

    // R2 sync into temp LSB (sync_sel=4), temp only
    cfg_en = 4'b0010; sync_sel = 3'd4; sync_in = 1; tp = 16'hAAA0;
    tick(ovf);
    pop_check(2, "R2");

    // R5 empty pop returns last byte, count stays 0
    rd(2'd0, v);
    check(v == last_pop, "R5", v, last_pop);
    count_check("R5");

    // R6 count unchanged mid-write; second tick ignored while busy
    cfg_en = 4'hF; rand_inputs();
    begin
      logic [7:0] b[$];
      void'(set_bytes(b));
      sample_tick = 1; @(negedge clk);
      sample_tick = 1; @(negedge clk); sample_tick = 0;
      rd(2'd1, h); rd(2'd2, l);
      check({h, l} == 0, "R6", {h, l}, 0);
      repeat (MAXW) @(negedge clk);
      foreach (b[i]) mq.push_back(b[i]);
    end
    count_check("R6");
    pop_check(16, "R6");

    // R3 latch: count high read latches low; low stays after count changes
    cfg_en = 4'h1; tick(ovf);
    rd(2'd1, h);
    pop_check(1, "R3");
    rd(2'd2, l);
    check({h, l} == 16'd6, "R3", {h, l}, 6);
    pop_check(5, "R4");

    // random phase: R1 R2 R4
    for (int it = 0; it < 40; it++) begin
      cfg_en = 4'($urandom); rand_inputs();
      tick(ovf);
      count_check("R1");
      begin
        int k = int'($urandom_range(0, 20));
        if (k > mq.size()) k = mq.size();
        pop_check(k, "R4");
      end
    end
    pop_check(mq.size(), "R4");

    // R9 fifo reset
    cfg_en = 4'hF; rand_inputs(); tick(ovf);
    fifo_rst = 1; @(negedge clk); fifo_rst = 0;
    mq = {};
    count_check("R9");

    // R7 overflow: 64 full sets fill 1024, 65th drops 16 oldest
    irq_ack = 1; @(negedge clk); irq_ack = 0;
    for (int s = 0; s < 64; s++) begin rand_inputs(); tick(ovf); end
    check(irq_overflow == 0, "R7", irq_overflow, 0);
    count_check("R7");
    rand_inputs(); tick(ovf);
    check(ovf == 1 && irq_overflow == 1, "R7", irq_overflow, 1);
    count_check("R7");
    pop_check(DEPTH, "R7");
    rd(2'd0, v);
    check(v == last_pop, "R5", v, last_pop);
    count_check("R5");

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule